// File: doc/BRIEF.md
# Winding Current Chopper with Decay Selection

This block regulates the current in one winding of a bipolar stepper motor by fixed-frequency chopping. It owns the four gate enables of one H-bridge, a high-side and a low-side switch for each of the two legs. An external comparator says when the sensed winding current has reached the scaled reference, and the step indexer supplies the winding polarity, the current magnitude and whether that magnitude is falling. An enable and a decay-mode select complete the inputs.

Every PWM period opens with a drive phase that pushes current through the winding in the commanded polarity. A comparator trip ends the drive phase and starts a decay phase. Trips are ignored in a blanking window at the start of the period, and this window also sets the minimum on time. The decay is either a brake through both low sides (slow), or a reversed bridge (fast) that changes to slow at a fixed fraction of the period (mixed). Mixed decay is used only while the indexer reports a falling magnitude. A zero-current indication during fast decay turns the bridge off until the slow part of the period begins. Each leg has its own dead-time stage, so that its two switches are never on together.

Top module: `pwm_chopper`

## Requirements
- R1: After reset all four gate outputs are low. A free-running period count starts at 0, counts up by one per clock and wraps after PERIOD_CYC-1. The first drive phase starts in the cycle in which the count first wraps to 0.
- R2: While enabled with a nonzero magnitude, the mode becomes drive whenever the count wraps to 0. With wind_pos=1, drive turns on hi_a and lo_b. With wind_pos=0, drive turns on hi_b and lo_a. Without a trip, drive lasts the whole period. Gate outputs follow a mode change one clock later, plus any dead time.
- R3: A cur_trip sampled while the count is below BLANK_CYC has no effect. A trip sampled at any later count during drive ends the drive phase at the next clock.
- R4: With mixed_sel=0, a trip during drive selects slow decay: lo_a and lo_b on, both high sides off, until the next period.
- R5: With mixed_sel=1 and mag_dec=1, a trip sampled at a count below FAST_END-1 (FAST_END = PERIOD_CYC*FAST_PCT/100) selects fast decay, which is the drive pattern with the polarity reversed. At count FAST_END the mode becomes slow decay.
- R6: With mixed_sel=1 and mag_dec=0, a trip selects slow decay.
- R7: With mixed_sel=1 and mag_dec=1, a trip sampled at a count of FAST_END-1 or above selects slow decay directly.
- R8: If cur_zero is sampled high during fast decay, all four gates turn off. They stay off until the count reaches FAST_END, and slow decay follows from there.
- R9: The high side and the low side of one leg are never on in the same cycle.
- R10: A gate turns on only after both gates of its leg have been off for at least DEAD_CYC consecutive cycles.
- R11: If drive_en is low or wind_mag is zero for two consecutive sampled cycles, all gates are low. After the condition clears, drive resumes only at the next wrap of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Enables the bridge when high |
| cur_trip | input | 1 | Comparator: winding current has reached the reference |
| cur_zero | input | 1 | Winding current is near zero |
| wind_pos | input | 1 | Commanded polarity: 1 drives current from leg a to leg b |
| wind_mag | input | MAG_W | Commanded magnitude from the indexer; zero turns the bridge off |
| mag_dec | input | 1 | Indexer reports that the magnitude is falling |
| mixed_sel | input | 1 | 0 selects slow decay, 1 selects mixed decay |
| hi_a | output | 1 | Leg a high-side gate enable |
| lo_a | output | 1 | Leg a low-side gate enable |
| hi_b | output | 1 | Leg b high-side gate enable |
| lo_b | output | 1 | Leg b low-side gate enable |

## Verification
The state that is hardest to reach from the ports is the coast after a zero-current indication. It needs a falling magnitude, mixed decay, a trip that arrives just after blanking but before the fast window closes, and then a zero pulse inside that window. The stimulus times all of these against the period count, which is known from reset. The first trip is placed right at the blanking edge, and a later trip lands after the three-quarter point. Together they pin down both window boundaries, and every switch-over is sampled cycle by cycle so that the dead-time gaps between switches are visible at the outputs.

// File: rtl/pwm_chopper_pkg.sv
package pwm_chopper_pkg;

   typedef enum logic [2:0] {
      MODE_OFF   = 3'd0,
      MODE_DRIVE = 3'd1,
      MODE_FAST  = 3'd2,
      MODE_COAST = 3'd3,
      MODE_SLOW  = 3'd4
   } chop_mode_e;

   typedef struct packed {
      logic hs;
      logic ls;
   } leg_req_t;

   // Requested switch pattern {hi_a, lo_a, hi_b, lo_b} for a mode and polarity.
   function automatic logic [3:0] gate_pattern(chop_mode_e mode, logic pos);
      logic [3:0] pat;
      case (mode)
         MODE_DRIVE: pat = pos ? 4'b1001 : 4'b0110;
         MODE_FAST:  pat = pos ? 4'b0110 : 4'b1001;
         MODE_SLOW:  pat = 4'b0101;
         default:    pat = 4'b0000;
      endcase
      return pat;
   endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
   parameter int PERIOD_CYC = 2500,
   parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

   assign wrap = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/chop_mode_fsm.sv
module chop_mode_fsm
   import pwm_chopper_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int BLANK_CYC = 469,
   parameter int FAST_END  = 1875
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap,
   input  logic             active,
   input  logic             trip,
   input  logic             zero,
   input  logic             falling,
   input  logic             mixed,
   output chop_mode_e       mode
);
   localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_CYC);
   localparam logic [CNT_W-1:0] FLAST_C = CNT_W'(FAST_END - 1);

   logic blank_done, fast_open, fast_last, use_fast;

   assign blank_done = (cnt >= BLANK_C);
   assign fast_open  = (cnt <  FLAST_C);
   assign fast_last  = (cnt == FLAST_C);
   assign use_fast   = mixed && falling && fast_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_OFF;
      end else if (!active) begin
         mode <= MODE_OFF;
      end else if (wrap) begin
         mode <= MODE_DRIVE;
      end else begin
         case (mode)
            MODE_DRIVE:
               if (trip && blank_done) mode <= use_fast ? MODE_FAST : MODE_SLOW;
            MODE_FAST:
               if (fast_last)          mode <= MODE_SLOW;
               else if (zero)          mode <= MODE_COAST;
            MODE_COAST:
               if (fast_last)          mode <= MODE_SLOW;
            default:                   mode <= mode;
         endcase
      end
   end
endmodule

// File: rtl/chop_dead_leg.sv
module chop_dead_leg
   import pwm_chopper_pkg::*;
#(
   parameter int DEAD_CYC = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_req_t req,
   output logic     hs_o,
   output logic     ls_o
);
   logic ready;

   generate
      if (DEAD_CYC == 1) begin : g_single
         // One full cycle with both switches off has always elapsed at the edge.
         assign ready = 1'b1;
      end else begin : g_count
         localparam int IW = $clog2(DEAD_CYC + 1);
         localparam logic [IW-1:0] SAT = IW'(DEAD_CYC - 1);
         logic [IW-1:0] idle;
         assign ready = (idle == SAT);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              idle <= SAT;
            else if (hs_o || ls_o)   idle <= '0;
            else if (idle != SAT)    idle <= idle + IW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_o <= 1'b0;
         ls_o <= 1'b0;
      end else begin
         hs_o <= hs_o ? req.hs : (req.hs && !req.ls && !ls_o && ready);
         ls_o <= ls_o ? req.ls : (req.ls && !req.hs && !hs_o && ready);
      end
   end
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
   import pwm_chopper_pkg::*;
#(
   parameter int PERIOD_CYC = 2500,
   parameter int BLANK_CYC  = 469,
   parameter int FAST_PCT   = 75,
   parameter int DEAD_CYC   = 4,
   parameter int MAG_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive_en,
   input  logic             cur_trip,
   input  logic             cur_zero,
   input  logic             wind_pos,
   input  logic [MAG_W-1:0] wind_mag,
   input  logic             mag_dec,
   input  logic             mixed_sel,
   output logic             hi_a,
   output logic             lo_a,
   output logic             hi_b,
   output logic             lo_b
);
   localparam int CNT_W    = $clog2(PERIOD_CYC);
   localparam int FAST_END = (PERIOD_CYC * FAST_PCT) / 100;
   localparam int N_LEGS   = 2;

   generate
      if (PERIOD_CYC < 8)
         $error("PERIOD_CYC must be at least 8");
      if (FAST_PCT < 1 || FAST_PCT > 99)
         $error("FAST_PCT must lie in 1..99");
      if (BLANK_CYC < 1 || BLANK_CYC >= FAST_END)
         $error("BLANK_CYC must be positive and end before the fast window");
      if (DEAD_CYC < 1)
         $error("DEAD_CYC must be at least 1");
      if (MAG_W < 1)
         $error("MAG_W must be at least 1");
   endgenerate

   logic [CNT_W-1:0] period_cnt;
   logic             period_wrap;
   logic             active;
   chop_mode_e       mode;
   logic [3:0]       pat;
   leg_req_t         req   [N_LEGS];
   logic             hs_q  [N_LEGS];
   logic             ls_q  [N_LEGS];

   assign active = drive_en && (wind_mag != '0);

   chop_period_timer #(
      .PERIOD_CYC (PERIOD_CYC),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (period_cnt),
      .wrap  (period_wrap)
   );

   chop_mode_fsm #(
      .CNT_W     (CNT_W),
      .BLANK_CYC (BLANK_CYC),
      .FAST_END  (FAST_END)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (period_cnt),
      .wrap    (period_wrap),
      .active  (active),
      .trip    (cur_trip),
      .zero    (cur_zero),
      .falling (mag_dec),
      .mixed   (mixed_sel),
      .mode    (mode)
   );

   assign pat = gate_pattern(mode, wind_pos);

   generate
      for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
         assign req[g].hs = pat[3 - 2*g];
         assign req[g].ls = pat[2 - 2*g];
         chop_dead_leg #(
            .DEAD_CYC (DEAD_CYC)
         ) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[g]),
            .hs_o  (hs_q[g]),
            .ls_o  (ls_q[g])
         );
      end
   endgenerate

   assign hi_a = hs_q[0];
   assign lo_a = ls_q[0];
   assign hi_b = hs_q[1];
   assign lo_b = ls_q[1];
endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk
   import pwm_chopper_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int MAG_W     = 8,
   parameter int BLANK_CYC = 469,
   parameter int FAST_END  = 1875,
   parameter int DEAD_CYC  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             drive_en,
   input logic [MAG_W-1:0] wind_mag,
   input logic             mag_dec,
   input logic             mixed_sel,
   input logic             hi_a,
   input logic             lo_a,
   input logic             hi_b,
   input logic             lo_b,
   input logic [CNT_W-1:0] period_cnt,
   input chop_mode_e       mode
);
   localparam int GW = $clog2(DEAD_CYC + 2);
   localparam logic [GW-1:0] GSAT = GW'(DEAD_CYC);

   logic [GW-1:0] gap_a, gap_b;
   logic          kill;

   assign kill = !drive_en || (wind_mag == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_a <= GSAT;
         gap_b <= GSAT;
      end else begin
         gap_a <= (hi_a || lo_a) ? '0 : ((gap_a == GSAT) ? GSAT : gap_a + GW'(1));
         gap_b <= (hi_b || lo_b) ? '0 : ((gap_b == GSAT) ? GSAT : gap_b + GW'(1));
      end
   end

   p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_a && lo_a) && !(hi_b && lo_b));

   p_dead_hi_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_a) |-> gap_a >= GSAT);
   p_dead_lo_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_a) |-> gap_a >= GSAT);
   p_dead_hi_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_b) |-> gap_b >= GSAT);
   p_dead_lo_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_b) |-> gap_b >= GSAT);

   p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (period_cnt != '0 && period_cnt <= CNT_W'(BLANK_CYC) &&
       $past(mode) == MODE_DRIVE && !$past(kill)) |-> mode == MODE_DRIVE);

   p_fast_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (period_cnt >= CNT_W'(FAST_END)) |-> (mode != MODE_FAST && mode != MODE_COAST));

   p_fast_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_FAST && $past(mode) != MODE_FAST) |-> $past(mixed_sel && mag_dec));

   p_kill_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(kill) && $past(kill, 2)) |-> !(hi_a || lo_a || hi_b || lo_b));
endmodule

bind pwm_chopper pwm_chopper_chk #(
   .CNT_W     (CNT_W),
   .MAG_W     (MAG_W),
   .BLANK_CYC (BLANK_CYC),
   .FAST_END  (FAST_END),
   .DEAD_CYC  (DEAD_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .drive_en   (drive_en),
   .wind_mag   (wind_mag),
   .mag_dec    (mag_dec),
   .mixed_sel  (mixed_sel),
   .hi_a       (hi_a),
   .lo_a       (lo_a),
   .hi_b       (hi_b),
   .lo_b       (lo_b),
   .period_cnt (period_cnt),
   .mode       (mode)
);

// File: tb/sim_pwm_chopper.sv
module sim_pwm_chopper;
   localparam int MAG_W = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             drive_en, cur_trip, cur_zero, wind_pos, mag_dec, mixed_sel;
   logic [MAG_W-1:0] wind_mag;
   logic             hi_a, lo_a, hi_b, lo_b;
   logic [3:0]       gates;

   int n_run  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      int         at;
      logic [3:0] g;
      string      tag;
   } exp_t;

   exp_t sbq[$];
   exp_t cur;

   always #4 clk = ~clk;

   pwm_chopper #(
      .PERIOD_CYC (40),
      .BLANK_CYC  (6),
      .FAST_PCT   (75),
      .DEAD_CYC   (2),
      .MAG_W      (MAG_W)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .drive_en  (drive_en),
      .cur_trip  (cur_trip),
      .cur_zero  (cur_zero),
      .wind_pos  (wind_pos),
      .wind_mag  (wind_mag),
      .mag_dec   (mag_dec),
      .mixed_sel (mixed_sel),
      .hi_a      (hi_a),
      .lo_a      (lo_a),
      .hi_b      (hi_b),
      .lo_b      (lo_b)
   );

   assign gates = {hi_a, lo_a, hi_b, lo_b};

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // Driver side of the scoreboard: expected gate pattern after a given edge.
   task automatic expect_at(input int at, input logic [3:0] g, input string tag);
      exp_t e;
      e.at = at; e.g = g; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic at_cycle(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // Monitor: pops and compares away from the active edge.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].at == cyc) begin
         cur = sbq.pop_front();
         n_run++;
         if (gates !== cur.g) begin
            n_fail++;
            $display("FAIL %s cycle %0d: gates {hi_a,lo_a,hi_b,lo_b} actual %b expected %b",
                     cur.tag, cyc, gates, cur.g);
         end
      end
   end

   initial begin
      rst_n = 1'b0; drive_en = 1'b1; cur_trip = 1'b0; cur_zero = 1'b0;
      wind_pos = 1'b1; wind_mag = 4'd5; mag_dec = 1'b0; mixed_sel = 1'b0;

      expect_at(  5, 4'b0000, "R1");   // off after reset
      expect_at( 39, 4'b0000, "R1");   // still off before first wrap
      expect_at( 41, 4'b1001, "R2");   // positive drive
      expect_at( 46, 4'b1001, "R3");   // trips at counts 1..5 ignored
      expect_at( 47, 4'b1001, "R3");
      expect_at( 48, 4'b0001, "R4");   // hi_a released, lo_a waits
      expect_at( 49, 4'b0001, "R10");
      expect_at( 50, 4'b0101, "R4");   // brake on both low sides
      expect_at( 79, 4'b0101, "R4");
      expect_at( 81, 4'b0001, "R2");
      expect_at( 82, 4'b0001, "R10");
      expect_at( 83, 4'b1001, "R2");
      expect_at(100, 4'b1001, "R2");   // no trip: drive all period
      expect_at(128, 4'b0000, "R10");
      expect_at(130, 4'b0110, "R5");   // fast decay, reversed
      expect_at(149, 4'b0110, "R9");
      expect_at(151, 4'b0100, "R5");   // three-quarter point: to slow
      expect_at(153, 4'b0101, "R5");
      expect_at(163, 4'b1001, "R2");
      expect_at(188, 4'b0001, "R6");   // mixed but rising: slow
      expect_at(189, 4'b0101, "R6");
      expect_at(203, 4'b1001, "R2");
      expect_at(233, 4'b0001, "R7");   // late trip: slow directly
      expect_at(235, 4'b0101, "R7");
      expect_at(250, 4'b0110, "R5");
      expect_at(257, 4'b0000, "R8");   // zero detect: coast
      expect_at(269, 4'b0000, "R8");
      expect_at(271, 4'b0101, "R8");
      expect_at(283, 4'b1001, "R2");
      expect_at(286, 4'b0000, "R10");  // polarity flip mid drive
      expect_at(287, 4'b0000, "R9");
      expect_at(288, 4'b0110, "R2");
      expect_at(301, 4'b0110, "R11");
      expect_at(302, 4'b0000, "R11");  // zero magnitude
      expect_at(325, 4'b0000, "R11");
      expect_at(359, 4'b0000, "R11");  // waits for wrap after restore
      expect_at(361, 4'b0110, "R2");
      expect_at(371, 4'b0110, "R11");
      expect_at(372, 4'b0000, "R11");  // disabled
      expect_at(399, 4'b0000, "R11");
      expect_at(401, 4'b0110, "R11");

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      at_cycle(41);  cur_trip = 1'b1;
      at_cycle(60);  cur_trip = 1'b0;
      at_cycle(100); mixed_sel = 1'b1; mag_dec = 1'b1;
      at_cycle(125); cur_trip = 1'b1;
      at_cycle(130); cur_trip = 1'b0;
      at_cycle(165); mag_dec = 1'b0;
      at_cycle(185); cur_trip = 1'b1;
      at_cycle(190); cur_trip = 1'b0;
      at_cycle(205); mag_dec = 1'b1;
      at_cycle(231); cur_trip = 1'b1;
      at_cycle(236); cur_trip = 1'b0;
      at_cycle(245); cur_trip = 1'b1;
      at_cycle(255); cur_zero = 1'b1;
      at_cycle(258); cur_trip = 1'b0;
      at_cycle(260); cur_zero = 1'b0;
      at_cycle(285); wind_pos = 1'b0;
      at_cycle(300); wind_mag = '0;
      at_cycle(330); wind_mag = 4'd5;
      at_cycle(370); drive_en = 1'b0;
      at_cycle(380); drive_en = 1'b1;
      at_cycle(405);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1: actual cycle %0d, expected completion by 405", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule